// File: doc/BRIEF.md
# Predicated Halfword Gather Load Sequencer

This block performs one vector gather of 16-bit values from memory. A start pulse captures a 64-bit base, a vector of per-element offsets, a governing predicate and the configuration: element size, offset width, offset signedness and scale. The block then visits the elements one at a time, from the lowest index to the highest. For each active element it forms an address and issues a single 16-bit read on a valid/ready memory port. It places each returned halfword, zero-widened, into that element's slot of the result.

Elements whose predicate bit is clear never reach the memory port. Their slots read as zero. When the last element has been handled, the block presents the full result vector together with a one-cycle done pulse. A base-register selector of 31 picks the stack-pointer input as the base. In that case the block raises an alignment-check flag when the rules below call for one.

Top module: `halfword_gather`

## Requirements
- R1: Elements are processed in ascending index order. There are VEC_BITS/32 elements when `cfgElemWide`=0 and VEC_BITS/64 elements when `cfgElemWide`=1. Reads on the memory port leave in the same ascending order.
- R2: The read address for element e is the base plus the extended offset, shifted left by one when `cfgScale`=1 and unshifted when `cfgScale`=0. The sum is 64-bit modular and wraps without any flag. Addresses need no alignment.
- R3: Offset extension. With `cfgElemWide`=1 and `cfgOffWide`=1 the full 64-bit lane is the offset, taken as unsigned. In every other case only the low 32 bits of the lane are used. These bits are zero-extended when `cfgOffSigned`=0 and sign-extended when `cfgOffSigned`=1. With 32-bit elements, `cfgOffWide` has no effect.
- R4: An element is active when predicate bit e*4 is set (32-bit elements) or predicate bit e*8 is set (64-bit elements). Other predicate bits are ignored. An inactive element issues no read, and its result slot is zero.
- R5: A returned halfword is zero-extended into its slot. Element e occupies `resultVec` bits [e*32 +: 32] or [e*64 +: 64], depending on the element size.
- R6: At most one read is outstanding. `memReqValid` stays high with a stable `memReqAddr` until `memReqReady` is sampled high. After a request is accepted, no new request is made until its response arrives.
- R7: `done` is high for exactly one cycle. That cycle is the one after the last element completes, which is either its response or the skip of an inactive last element. `resultVec` holds its value until the next accepted start.
- R8: A start pulse that arrives while a gather is in progress is ignored. The running gather keeps the inputs it captured.
- R9: When `baseReg`=31, `spBase` is used as the base; otherwise `gprBase` is used. `spAlignFlag` is set when `baseReg`=31 and either some element is active or `cfgSpIdleChk`=1. In all other cases it is clear.
- R10: After reset, `done`, `memReqValid` and `spAlignFlag` are 0 and `resultVec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather (accepted only when idle) |
| gprBase | input | 64 | General-register base value |
| spBase | input | 64 | Stack-pointer base value |
| baseReg | input | 5 | Base selector; 31 selects `spBase` |
| offVec | input | VEC_BITS | Per-element offset lanes |
| predVec | input | VEC_BITS/8 | Governing predicate, one bit per byte |
| cfgElemWide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| cfgOffWide | input | 1 | 1: 64-bit offset (64-bit elements only) |
| cfgOffSigned | input | 1 | Sign-extend a 32-bit offset |
| cfgScale | input | 1 | Shift offset left by one |
| cfgSpIdleChk | input | 1 | Flag alignment check even with no active element |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 64 | Read byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | Read halfword |
| done | output | 1 | One-cycle completion pulse |
| resultVec | output | VEC_BITS | Gathered result vector |
| spAlignFlag | output | 1 | Stack-pointer alignment check required |

## Verification
Every cycle, the assertions check the port protocol: requests are held stable until accepted, a new request never follows directly on an accepted one, `done` lasts a single cycle, and the element index stays inside the element count. They also check that a request is only made for an active element. Only the bench scenarios can show the following:
- the addresses are correct under each extension and scale combination, including wraparound;
- the reads come out in ascending order;
- inactive lanes are zeroed;
- the stack-pointer flag decision is right;
- a start pulse given mid-gather is truly ignored.

// File: rtl/gthr_pkg.sv
package gthr_pkg;
  typedef struct packed {
    logic load;
    logic wrLane;
    logic advance;
  } gthr_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } gthr_state_t;
endpackage

// File: rtl/gthr_ctrl.sv
module gthr_ctrl
  import gthr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         curActive,
  input  logic         isLast,
  input  logic         memReqReady,
  input  logic         memRspValid,
  output gthr_strobe_t stb,
  output logic         memReqValid,
  output logic         doneOut
);
  gthr_state_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        nxtState = ST_EVAL;
      end
      ST_EVAL: begin
        if (curActive)   nxtState = ST_REQ;
        else if (isLast) nxtState = ST_DONE;
        else             stb.advance = 1'b1;
      end
      ST_REQ: if (memReqReady) nxtState = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        stb.wrLane = 1'b1;
        if (isLast) nxtState = ST_DONE;
        else begin
          stb.advance = 1'b1;
          nxtState    = ST_EVAL;
        end
      end
      ST_DONE: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_REQ);
  assign doneOut     = (state == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid); // R6
  AST_ACTIVE_ONLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> curActive); // R4
endmodule

// File: rtl/gthr_dpath.sv
module gthr_dpath
  import gthr_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gthr_strobe_t          stb,
  input  logic [63:0]           gprBase,
  input  logic [63:0]           spBase,
  input  logic [4:0]            baseReg,
  input  logic [VEC_BITS-1:0]   offVec,
  input  logic [VEC_BITS/8-1:0] predVec,
  input  logic                  cfgElemWide,
  input  logic                  cfgOffWide,
  input  logic                  cfgOffSigned,
  input  logic                  cfgScale,
  input  logic                  cfgSpIdleChk,
  input  logic [15:0]           memRspData,
  output logic                  curActive,
  output logic                  isLast,
  output logic [63:0]           memReqAddr,
  output logic [VEC_BITS-1:0]   resultVec,
  output logic                  spAlignFlag
);
  localparam int PRED_BITS = VEC_BITS / 8;
  localparam int MAX_ELEMS = VEC_BITS / 32;
  localparam int NUM_WIDE  = VEC_BITS / 64;
  localparam int IDX_W     = $clog2(MAX_ELEMS);
  localparam logic [4:0] SP_SEL = 5'd31;

  logic [VEC_BITS-1:0]  offR;
  logic [PRED_BITS-1:0] predR;
  logic [63:0]          baseR;
  logic                 elemWideR, offWideR, signedR, scaleR;
  logic [IDX_W-1:0]     idx;
  logic [VEC_BITS-1:0]  resultR;
  logic                 alignR;

  // Active flags at capture time, one per candidate element of each size
  logic [MAX_ELEMS-1:0] narrowAct;
  logic [NUM_WIDE-1:0]  wideAct;
  logic                 anyAct;

  for (genvar k = 0; k < MAX_ELEMS; k++) begin : g_narrow
    assign narrowAct[k] = predVec[k*4];
  end
  for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
    assign wideAct[k] = predVec[k*8];
  end
  assign anyAct = cfgElemWide ? |wideAct : |narrowAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offR      <= '0;
      predR     <= '0;
      baseR     <= '0;
      elemWideR <= 1'b0;
      offWideR  <= 1'b0;
      signedR   <= 1'b0;
      scaleR    <= 1'b0;
      idx       <= '0;
      resultR   <= '0;
      alignR    <= 1'b0;
    end else begin
      if (stb.load) begin
        offR      <= offVec;
        predR     <= predVec;
        baseR     <= (baseReg == SP_SEL) ? spBase : gprBase;
        elemWideR <= cfgElemWide;
        offWideR  <= cfgOffWide;
        signedR   <= cfgOffSigned;
        scaleR    <= cfgScale;
        idx       <= '0;
        resultR   <= '0;
        alignR    <= (baseReg == SP_SEL) && (anyAct || cfgSpIdleChk);
      end
      if (stb.wrLane) begin
        if (elemWideR) resultR[{idx, 6'b0} +: 16] <= memRspData;
        else           resultR[{idx, 5'b0} +: 16] <= memRspData;
      end
      if (stb.advance) idx <= idx + 1'b1;
    end
  end

  // Lane extraction and offset extension
  logic [31:0] narrowLane;
  logic [63:0] wideLane;
  logic [31:0] lowOff;
  logic [63:0] offExt;
  logic [63:0] offScaled;

  assign narrowLane = offR[{idx, 5'b0} +: 32];
  assign wideLane   = offR[{idx, 6'b0} +: 64];
  assign lowOff     = elemWideR ? wideLane[31:0] : narrowLane;

  always_comb begin
    if (elemWideR && offWideR) offExt = wideLane;
    else if (signedR)          offExt = {{32{lowOff[31]}}, lowOff};
    else                       offExt = {32'b0, lowOff};
  end

  assign offScaled  = scaleR ? {offExt[62:0], 1'b0} : offExt;
  assign memReqAddr = baseR + offScaled;

  assign curActive = elemWideR ? predR[{idx, 3'b0}] : predR[{idx, 2'b0}];
  assign isLast    = elemWideR ? (idx == IDX_W'(NUM_WIDE - 1))
                               : (idx == IDX_W'(MAX_ELEMS - 1));

  assign resultVec   = resultR;
  assign spAlignFlag = alignR;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    elemWideR |-> (int'(idx) < NUM_WIDE)); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (idx == $past(idx) + 1'b1)); // R1
endmodule

// File: rtl/halfword_gather.sv
module halfword_gather
  import gthr_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [63:0]           gprBase,
  input  logic [63:0]           spBase,
  input  logic [4:0]            baseReg,
  input  logic [VEC_BITS-1:0]   offVec,
  input  logic [VEC_BITS/8-1:0] predVec,
  input  logic                  cfgElemWide,
  input  logic                  cfgOffWide,
  input  logic                  cfgOffSigned,
  input  logic                  cfgScale,
  input  logic                  cfgSpIdleChk,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [63:0]           memReqAddr,
  input  logic                  memRspValid,
  input  logic [15:0]           memRspData,
  output logic                  done,
  output logic [VEC_BITS-1:0]   resultVec,
  output logic                  spAlignFlag
);
  gthr_strobe_t stb;
  logic         curActive;
  logic         isLast;

  gthr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .curActive   (curActive),
    .isLast      (isLast),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stb         (stb),
    .memReqValid (memReqValid),
    .doneOut     (done)
  );

  gthr_dpath #(.VEC_BITS(VEC_BITS)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .gprBase      (gprBase),
    .spBase       (spBase),
    .baseReg      (baseReg),
    .offVec       (offVec),
    .predVec      (predVec),
    .cfgElemWide  (cfgElemWide),
    .cfgOffWide   (cfgOffWide),
    .cfgOffSigned (cfgOffSigned),
    .cfgScale     (cfgScale),
    .cfgSpIdleChk (cfgSpIdleChk),
    .memRspData   (memRspData),
    .curActive    (curActive),
    .isLast       (isLast),
    .memReqAddr   (memReqAddr),
    .resultVec    (resultVec),
    .spAlignFlag  (spAlignFlag)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(done) |-> $stable(resultVec)); // R7
endmodule

// File: tb/halfword_gather_tb.sv
module halfword_gather_tb;
  localparam int VB = 128;
  localparam int PB = VB / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   gprBase = '0, spBase = '0;
  logic [4:0]    baseReg = '0;
  logic [VB-1:0] offVec = '0;
  logic [PB-1:0] predVec = '0;
  logic          cfgElemWide = 0, cfgOffWide = 0, cfgOffSigned = 0, cfgScale = 0, cfgSpIdleChk = 0;
  logic          memReqValid, memReqReady = 1'b0;
  logic [63:0]   memReqAddr;
  logic          memRspValid = 1'b0;
  logic [15:0]   memRspData = '0;
  logic          done;
  logic [VB-1:0] resultVec;
  logic          spAlignFlag;

  int tests = 0, fails = 0;
  int cyc = 0, lastRsp = 0, doneCyc = 0;
  int logN = 0;
  logic [63:0] logA [0:1023];
  int ph = 0, pend = 0;
  logic [63:0] pendAddr = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  halfword_gather #(.VEC_BITS(VB)) u_dut (.*);

  function automatic logic [15:0] memVal(logic [63:0] a);
    return a[16:1] ^ a[63:48] ^ 16'h5A3C;
  endfunction

  // Memory model: irregular ready, two-cycle response latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    ph  <= ph + 1;
    memReqReady <= (ph % 3) != 0;
    if (memReqValid && memReqReady) begin
      logA[logN] <= memReqAddr;
      logN <= logN + 1;
      pend <= 2;
      pendAddr <= memReqAddr;
    end else if (pend != 0) pend <= pend - 1;
    memRspValid <= (pend == 1);
    memRspData  <= memVal(pendAddr);
    if (memRspValid) lastRsp <= cyc;
    if (done) doneCyc <= cyc;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expAddr(int e, bit ew, bit ow, bit sg, bit sc,
                                          logic [VB-1:0] ov, logic [63:0] b);
    logic [63:0] lane, ext;
    lane = ew ? ov[e*64 +: 64] : {32'b0, ov[e*32 +: 32]};
    if (ew && ow)  ext = lane;
    else if (sg)   ext = {{32{lane[31]}}, lane[31:0]};
    else           ext = {32'b0, lane[31:0]};
    return b + (sc ? {ext[62:0], 1'b0} : ext);
  endfunction

  task automatic runCase(bit ew, bit ow, bit sg, bit sc, logic [PB-1:0] pr,
                         logic [VB-1:0] ov, logic [63:0] gb, logic [63:0] sb,
                         logic [4:0] br, bit idleChk, bit midStart);
    int nE, startLog, nAct, k, wait_n;
    logic [63:0] b, a;
    logic [VB-1:0] expRes;
    bit lastAct, anyA, expAlign;
    @(negedge clk);
    cfgElemWide = ew; cfgOffWide = ow; cfgOffSigned = sg; cfgScale = sc;
    predVec = pr; offVec = ov; gprBase = gb; spBase = sb; baseReg = br;
    cfgSpIdleChk = idleChk;
    startLog = logN;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (3) @(negedge clk);
      gprBase = ~gb; spBase = ~sb; offVec = ~ov; predVec = ~pr; cfgScale = ~sc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    nE = ew ? VB / 64 : VB / 32;
    b = (br == 5'd31) ? sb : gb;
    nAct = 0; expRes = '0; anyA = 0; lastAct = 0;
    for (int e = 0; e < nE; e++) begin
      bit act;
      act = ew ? pr[e*8] : pr[e*4];
      if (act) begin
        a = expAddr(e, ew, ow, sg, sc, ov, b);
        k = startLog + nAct;
        chk(logA[k] == a, midStart ? "R8 addr after ignored start" : "R1/R2/R3 address order",
            {64'b0, logA[k]}, {64'b0, a});
        if (ew) expRes[e*64 +: 64] = {48'b0, memVal(a)};
        else    expRes[e*32 +: 32] = {16'b0, memVal(a)};
        nAct++;
        anyA = 1;
        if (e == nE - 1) lastAct = 1;
      end
    end
    chk(done == 1'b1, "R7 done seen", {127'b0, done}, 128'd1);
    chk(logN - startLog == nAct, "R4 read count", 128'(logN - startLog), 128'(nAct));
    chk(resultVec == expRes, "R4/R5 result lanes", resultVec, expRes);
    expAlign = (br == 5'd31) && (anyA || idleChk);
    chk(spAlignFlag == expAlign, "R9 align flag", {127'b0, spAlignFlag}, {127'b0, expAlign});
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", {127'b0, done}, 128'd0);
    if (lastAct)
      chk(doneCyc - lastRsp == 1, "R7 done timing", 128'(doneCyc - lastRsp), 128'd1);
    repeat (2) @(negedge clk);
    chk(resultVec == expRes, "R7 result held", resultVec, expRes);
  endtask

  initial begin
    logic [PB-1:0] preds [4];
    logic [VB-1:0] ov;
    preds[0] = 16'hFFFF; preds[1] = 16'h0000; preds[2] = 16'h1010; preds[3] = 16'h0E01;
    ov = {32'hFFFF_FFF0, 32'h0000_1234, 32'h8000_0002, 32'h0000_0007};
    repeat (3) @(negedge clk);
    chk(done == 0 && memReqValid == 0 && spAlignFlag == 0 && resultVec == '0,
        "R10 reset state", {126'b0, done, memReqValid}, 128'd0);
    rstN = 1'b1;
    for (int ew = 0; ew < 2; ew++)
      for (int ow = 0; ow < 2; ow++)
        for (int sg = 0; sg < 2; sg++)
          for (int sc = 0; sc < 2; sc++)
            for (int pi = 0; pi < 4; pi++)
              runCase(ew[0], ow[0], sg[0], sc[0], preds[pi], ov ^ VB'(pi * 32'h0101_0003),
                      64'h0000_4000_0000_1000 + 64'(pi), 64'h0000_7FFF_0000_2000,
                      (pi % 2 == 1) ? 5'd31 : 5'd3, sc[0], 1'b0);
    // R2 wraparound near top of address space with negative offsets
    runCase(1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF, {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010},
            64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 5'd1, 1'b0, 1'b0);
    runCase(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, ov, 64'h0000_0000_0000_0004, 64'h0,
            5'd2, 1'b0, 1'b0);
    // R8 start while busy is ignored
    runCase(1'b0, 1'b0, 1'b1, 1'b1, 16'h1111, ov, 64'h0000_0000_1234_5670, 64'h0000_0000_0000_8000,
            5'd31, 1'b0, 1'b1);
    // R9 idle check with no active elements and stack base
    runCase(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, ov, 64'h10, 64'h20, 5'd31, 1'b1, 1'b0);
    runCase(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, ov, 64'h10, 64'h20, 5'd31, 1'b0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule